// File: doc/BRIEF.md
# Parallel I/O Port Controller with Peripheral Override

This block controls an 8-bit general-purpose I/O port. Software reaches four registers through a small register bus: an output latch, a per-bit direction mask, a per-bit pull-device enable and a per-bit slew-limit enable. The block combines these registers with per-pin override signals from one on-chip peripheral per pin. From them it drives the pad controls: output level, output enable, pullup, pulldown and slew limit. It also builds the value returned when software reads the data register.

Pad input levels pass through a two-stage synchronizer before they reach the read path. On the four upper pins, an edge-polarity input from a keyboard-wake function selects the pull direction. When a pin watches for rising edges, its pull enable switches on a pulldown rather than a pullup. Writes take one cycle and reads are combinational.

Top module: `gpio_port`

## Requirements
- R1: While reset is asserted and after it, the latch, direction, pull and slew registers are 0, so every pad has output enable, pullup, pulldown and slew limit all at 0.
- R2: A write with `wr_en` high loads `wdata` into the register chosen by `addr` (0 latch, 1 direction, 2 pull enable, 3 slew enable) at the clock edge. Reading addresses 1, 2 and 3 returns the direction, pull and slew registers.
- R3: A write to address 0 updates the latch even when the bit is an input or is owned by a peripheral.
- R4: A read of address 0 returns the latch bit where the direction bit is 1, and the synchronized pad level where it is 0.
- R5: For a bit with `periph_en` low, `pad_oe` equals the direction bit, and `pad_out` equals the latch bit ANDed with the direction bit.
- R6: For a bit with `periph_en` high, `pad_oe` equals `periph_oe` and `pad_out` equals `periph_out`. The address-0 read for that bit still follows the direction bit.
- R7: A pull device is active only where the pull bit is 1, the direction bit is 0 and the pad is not being driven. Otherwise `pad_pu` and `pad_pd` are 0.
- R8: For bits 7 to 4, `edge_rise[i-4]` high turns an active pull into a pulldown (`pad_pd`). Otherwise the active pull is a pullup (`pad_pu`). Bits 3 to 0 always use the pullup.
- R9: `pad_pu` and `pad_pd` are never both 1 on the same bit.
- R10: `pad_slew` is 1 where the slew bit is 1 and either the direction bit is 1 or the peripheral is enabled with `periph_oe` high.
- R11: A change on `pad_in` shows up in the address-0 read after exactly two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 latch, 1 direction, 2 pull, 3 slew |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `addr` |
| pad_in | input | 8 | Raw pad input levels |
| periph_en | input | 8 | Peripheral owns the pin |
| periph_out | input | 8 | Peripheral output level |
| periph_oe | input | 8 | Peripheral output enable |
| edge_rise | input | 4 | Rising-edge select for bits 7..4 (bit 0 maps to pin 4) |
| pad_out | output | 8 | Pad output level |
| pad_oe | output | 8 | Pad output-driver enable |
| pad_pu | output | 8 | Pullup enable |
| pad_pd | output | 8 | Pulldown enable |
| pad_slew | output | 8 | Slew-limit enable |

## Verification
The bench writes the latch while the pins are inputs and while a peripheral owns them, then turns the direction on. A design that dropped those writes would return stale data. The bench sets a mixed direction mask with a peripheral active, so a read path that followed pad ownership rather than the direction bit would return wrong bits. It also sets mixed rising-edge selects with pulls enabled, which exposes a swapped pull polarity, a select applied to the lower pins, or a pull left on while a pad is driven. A one-cycle check of the synchronizer catches a chain that is too short or too long.

// File: rtl/gpio_pkg.sv
`timescale 1ns/1ps
package gpio_pkg;
    typedef enum logic [1:0] {
        ADDR_DATA = 2'd0,
        ADDR_DIR  = 2'd1,
        ADDR_PULL = 2'd2,
        ADDR_SLEW = 2'd3
    } gpio_addr_e;
endpackage

// File: rtl/gpio_regs.sv
`timescale 1ns/1ps
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] data_q,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] pull_q,
    output logic [W-1:0] slew_q
);
    gpio_addr_e sel;
    assign sel = gpio_addr_e'(addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
            pull_q <= '0;
            slew_q <= '0;
        end else if (wr_en) begin
            unique case (sel)
                ADDR_DATA: data_q <= wdata;
                ADDR_DIR:  dir_q  <= wdata;
                ADDR_PULL: pull_q <= wdata;
                ADDR_SLEW: slew_q <= wdata;
            endcase
        end
    end

    AST_DATA_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_DATA) |=> (data_q == $past(wdata)))
        else $error("latch write lost"); // R3

    AST_DIR_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_DIR) |=> (dir_q == $past(wdata)))
        else $error("direction write lost"); // R2
endmodule

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_pad_ctrl.sv
`timescale 1ns/1ps
module gpio_pad_ctrl #(
    parameter int W       = 8,
    parameter int EDGE_LO = 4,
    localparam int EDGE_W = W - EDGE_LO
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      data_q,
    input  logic [W-1:0]      dir_q,
    input  logic [W-1:0]      pull_q,
    input  logic [W-1:0]      slew_q,
    input  logic [W-1:0]      periph_en,
    input  logic [W-1:0]      periph_out,
    input  logic [W-1:0]      periph_oe,
    input  logic [EDGE_W-1:0] edge_rise,
    output logic [W-1:0]      pad_out,
    output logic [W-1:0]      pad_oe,
    output logic [W-1:0]      pad_pu,
    output logic [W-1:0]      pad_pd,
    output logic [W-1:0]      pad_slew
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic drive;
        logic pull_on;
        logic rise;

        if (i >= EDGE_LO) begin : g_edge
            assign rise = edge_rise[i-EDGE_LO];
        end else begin : g_plain
            assign rise = 1'b0;
        end

        assign drive       = periph_en[i] ? periph_oe[i] : dir_q[i];
        assign pad_oe[i]   = drive;
        assign pad_out[i]  = periph_en[i] ? periph_out[i] : (data_q[i] & dir_q[i]);
        assign pull_on     = pull_q[i] & ~dir_q[i] & ~drive;
        assign pad_pu[i]   = pull_on & ~rise;
        assign pad_pd[i]   = pull_on & rise;
        assign pad_slew[i] = slew_q[i] & (dir_q[i] | (periph_en[i] & periph_oe[i]));
    end

    AST_PULL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_pd) == '0)
        else $error("pullup and pulldown together"); // R9

    AST_NO_PULL_ON_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_pu | pad_pd) & pad_oe) == '0)
        else $error("pull active on driven pad"); // R7
endmodule

// File: rtl/gpio_port.sv
`timescale 1ns/1ps
module gpio_port
    import gpio_pkg::*;
#(
    parameter int W           = 8,
    parameter int EDGE_LO     = 4,
    parameter int SYNC_STAGES = 2,
    localparam int EDGE_W     = W - EDGE_LO
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      rdata,
    input  logic [W-1:0]      pad_in,
    input  logic [W-1:0]      periph_en,
    input  logic [W-1:0]      periph_out,
    input  logic [W-1:0]      periph_oe,
    input  logic [EDGE_W-1:0] edge_rise,
    output logic [W-1:0]      pad_out,
    output logic [W-1:0]      pad_oe,
    output logic [W-1:0]      pad_pu,
    output logic [W-1:0]      pad_pd,
    output logic [W-1:0]      pad_slew
);
    logic [W-1:0] data_q, dir_q, pull_q, slew_q, pin_sync;

    gpio_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .data_q(data_q), .dir_q(dir_q), .pull_q(pull_q), .slew_q(slew_q)
    );

    gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_sync)
    );

    gpio_pad_ctrl #(.W(W), .EDGE_LO(EDGE_LO)) u_pad (
        .clk(clk), .rst_n(rst_n),
        .data_q(data_q), .dir_q(dir_q), .pull_q(pull_q), .slew_q(slew_q),
        .periph_en(periph_en), .periph_out(periph_out), .periph_oe(periph_oe),
        .edge_rise(edge_rise),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
        .pad_slew(pad_slew)
    );

    always_comb begin
        unique case (gpio_addr_e'(addr))
            ADDR_DATA: rdata = (data_q & dir_q) | (pin_sync & ~dir_q);
            ADDR_DIR:  rdata = dir_q;
            ADDR_PULL: rdata = pull_q;
            ADDR_SLEW: rdata = slew_q;
        endcase
    end
endmodule

// File: tb/sim_gpio_port.sv
`timescale 1ns/1ps
module sim_gpio_port;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [1:0] addr;
    logic [7:0] wdata, rdata, pad_in, periph_en, periph_out, periph_oe;
    logic [3:0] edge_rise;
    logic [7:0] pad_out, pad_oe, pad_pu, pad_pd, pad_slew;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    gpio_port u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pad_in(pad_in), .periph_en(periph_en),
        .periph_out(periph_out), .periph_oe(periph_oe), .edge_rise(edge_rise),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
        .pad_slew(pad_slew)
    );

    // selector: 0 rdata, 1 pad_out, 2 pad_oe, 3 pad_pu, 4 pad_pd, 5 pad_slew, 6 pu&pd
    typedef struct {
        string      req;
        int         sel;
        logic [7:0] exp;
    } item_t;

    item_t q[$];
    event  chk_ev;

    task automatic expect_val(string req, int sel, logic [7:0] e);
        item_t it;
        it.req = req; it.sel = sel; it.exp = e;
        q.push_back(it);
    endtask

    task automatic flush();
        -> chk_ev;
        #1;
    endtask

    task automatic rd_chk(string req, logic [1:0] a, logic [7:0] e);
        addr = a;
        #1;
        expect_val(req, 0, e);
        flush();
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin : monitor
        forever begin
            @chk_ev;
            while (q.size() > 0) begin
                item_t it;
                logic [7:0] got;
                it = q.pop_front();
                case (it.sel)
                    0: got = rdata;
                    1: got = pad_out;
                    2: got = pad_oe;
                    3: got = pad_pu;
                    4: got = pad_pd;
                    5: got = pad_slew;
                    default: got = pad_pu & pad_pd;
                endcase
                n_checks++;
                if (got !== it.exp) begin
                    n_err++;
                    $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, got, it.exp);
                end
            end
        end
    end

    initial begin : watchdog
        #200000;
        if (!done) begin
            n_err++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin : driver
        rst_n = 1'b0; wr_en = 1'b0; addr = 2'd0; wdata = 8'h00;
        pad_in = 8'hA5; periph_en = 8'h00; periph_out = 8'h00; periph_oe = 8'h00;
        edge_rise = 4'h0;
        repeat (3) @(negedge clk);
        // R1: state while in reset
        rd_chk("R1", 2'd1, 8'h00);
        rd_chk("R1", 2'd2, 8'h00);
        rd_chk("R1", 2'd3, 8'h00);
        expect_val("R1", 2, 8'h00);
        expect_val("R1", 3, 8'h00);
        expect_val("R1", 4, 8'h00);
        expect_val("R1", 5, 8'h00);
        flush();
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        rd_chk("R4", 2'd0, 8'hA5);
        // R11: two-edge synchronizer latency
        pad_in = 8'h3C;
        @(negedge clk);
        rd_chk("R11", 2'd0, 8'hA5);
        @(negedge clk);
        rd_chk("R11", 2'd0, 8'h3C);
        // R3: write latch while all pins are inputs
        wr(2'd0, 8'h5A);
        rd_chk("R3", 2'd0, 8'h3C);
        expect_val("R5", 2, 8'h00);
        expect_val("R5", 1, 8'h00);
        flush();
        wr(2'd1, 8'hFF);
        rd_chk("R3", 2'd0, 8'h5A);
        expect_val("R5", 2, 8'hFF);
        expect_val("R5", 1, 8'h5A);
        flush();
        // R4: mixed direction
        wr(2'd1, 8'h0F);
        rd_chk("R4", 2'd0, 8'h3A);
        expect_val("R5", 1, 8'h0A);
        expect_val("R5", 2, 8'h0F);
        flush();
        // R2: register readback
        rd_chk("R2", 2'd1, 8'h0F);
        wr(2'd2, 8'hFF);
        rd_chk("R2", 2'd2, 8'hFF);
        wr(2'd3, 8'hC3);
        rd_chk("R2", 2'd3, 8'hC3);
        // R10: slew follows direction
        expect_val("R10", 5, 8'h03);
        // R7: pulls only on input bits, pullup by default
        expect_val("R7", 3, 8'hF0);
        expect_val("R7", 4, 8'h00);
        flush();
        // R8: rising-edge select on bits 7 and 5
        edge_rise = 4'b1010;
        #1;
        expect_val("R8", 4, 8'hA0);
        expect_val("R8", 3, 8'h50);
        flush();
        wr(2'd1, 8'h00);
        expect_val("R8", 4, 8'hA0);
        expect_val("R8", 3, 8'h5F);
        expect_val("R9", 6, 8'h00);
        flush();
        // R6: peripheral owns upper nibble
        wr(2'd1, 8'h0F);
        wr(2'd3, 8'hFF);
        edge_rise = 4'h0;
        periph_en = 8'hF0; periph_oe = 8'h30; periph_out = 8'h10;
        #1;
        expect_val("R6", 2, 8'h3F);
        expect_val("R6", 1, 8'h1A);
        expect_val("R10", 5, 8'h3F);
        expect_val("R7", 3, 8'hC0);
        expect_val("R7", 4, 8'h00);
        flush();
        rd_chk("R6", 2'd0, 8'h3A);
        // R3: write latch while peripheral owns pins
        wr(2'd0, 8'hE7);
        rd_chk("R3", 2'd0, 8'h37);
        expect_val("R6", 1, 8'h17);
        flush();
        periph_en = 8'h00;
        wr(2'd1, 8'hFF);
        rd_chk("R3", 2'd0, 8'hE7);
        expect_val("R5", 1, 8'hE7);
        expect_val("R7", 3, 8'h00);
        flush();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule